// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block is a hardware watchdog for a small microcontroller. It sits on the special-function-register write bus, which carries an address, a data byte and a write strobe, and it runs from the oscillator clock. After reset it is idle. Software arms it by writing a fixed two-byte key to one write-only register address. Once armed, it can only be stopped by a hardware reset or by its own overflow.

While armed, a prescaler divides the oscillator clock into machine-cycle ticks. The machine cycle is 6 clocks in fast mode and 12 clocks in slow mode. A 14-bit counter advances on each tick. Software keeps the device running by writing the same two-byte key again. This restarts the count from zero.

If the count reaches all ones, the block raises an active-high reset output for a fixed number of oscillator clocks. The number depends on the mode. The overflow also returns the watchdog to its idle, disarmed state. The counter cannot be read or loaded.

Top module: `keyed_wdt`

## Requirements
- R1: After a clock edge with `rst` high, the watchdog is disarmed and `rst_out` is low. With no key written, `rst_out` stays low.
- R2: The watchdog arms when a write of 0x1E to address 0xA6 is followed by a write of 0xE1 to address 0xA6. Counting starts from zero at the edge that accepts the 0xE1 write.
- R3: Once armed, no register write disarms the watchdog. Writes of other values to 0xA6 leave the count running.
- R4: While armed, the count advances once per machine cycle. A machine cycle is 6 clocks when `mode_slow` is 0 and 12 clocks when it is 1.
- R5: Without service, `rst_out` rises at the edge that lies (2^CNT_W − 1) machine cycles after the accepting edge. At that edge the count reaches all ones.
- R6: Writing the key again while armed restarts both the count and the machine-cycle phase from zero. Overflow timing is then measured from the last key.
- R7: The key detector behaves as follows:
  - A write of 0xE1 to 0xA6 has no effect unless the previous write to 0xA6 was 0xE1's partner 0x1E.
  - After 0x1E, any other value written to 0xA6, including 0x1E again, returns the detector to waiting.
  - Writes to other addresses do not change the detector's state.
- R8: The reset pulse lasts 98 clocks in fast mode and 196 clocks in slow mode. The mode is sampled at the overflow edge.
- R9: Overflow disarms the watchdog and clears its counter. Key writes made while the pulse is high are ignored, so no further pulse follows until the watchdog is armed again.
- R10: A hardware reset during counting or during the pulse disarms the watchdog and drives `rst_out` low at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| mode_slow | input | 1 | 0: 6-clock machine cycle, 1: 12-clock machine cycle |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| sfr_we | input | 1 | Write strobe, one write per high cycle |
| rst_out | output | 1 | Active-high reset pulse on overflow |

## Verification
The bench aims at the key detector's edge cases and the exact timing of overflow:
- **Key detector.** The cases are a lone second byte, an interrupted key, a repeated first byte, and a foreign-address write placed between the two bytes. A detector that mishandles these would either arm spuriously, giving an unexpected pulse, or fail to arm, giving a missing pulse.
- **Overflow timing.** The bench measures the rising edge of the pulse to the exact cycle in both modes, and measures the pulse width. An off-by-one in the prescaler or in the overflow compare shows up as a wrong start cycle. A pulse stretcher that ignores the mode shows up as a wrong width.
- **Service, disarm and reset.** Repeated service must push the overflow out, and bad writes while armed must not disarm. Writes during the pulse must stay ignored. Reset during counting or during the pulse must cut everything off; a design that leaves state behind here produces a late pulse.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  typedef enum logic {
    KS_WAIT  = 1'b0,
    KS_FIRST = 1'b1
  } key_state_t;
endpackage

// File: rtl/kwdt_key_seq.sv
module kwdt_key_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_A = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B = 8'hE1
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              key_hit
);
  import kwdt_pkg::*;

  key_state_t st;
  logic       sel;

  assign sel     = wr_en && (wr_addr == REG_ADDR);
  assign key_hit = sel && (st == KS_FIRST) && (wr_data == KEY_B);

  always_ff @(posedge clk) begin
    if (clr) begin
      st <= KS_WAIT;
    end else if (sel) begin
      st <= ((st == KS_WAIT) && (wr_data == KEY_A)) ? KS_FIRST : KS_WAIT;
    end
  end

  AST_HIT_RETURNS_WAIT: assert property (@(posedge clk) disable iff (clr)
    key_hit |=> st == KS_WAIT); // R7
  AST_ABORT_AFTER_FIRST: assert property (@(posedge clk) disable iff (clr)
    (sel && st == KS_FIRST) |=> st == KS_WAIT); // R7
  AST_FOREIGN_HOLDS: assert property (@(posedge clk) disable iff (clr)
    !sel |=> $stable(st)); // R7
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
  parameter int DIV_FAST = 6,
  parameter int DIV_SLOW = 12
) (
  input  logic clk,
  input  logic clr,
  input  logic run,
  input  logic restart,
  input  logic slow_mode,
  output logic tick
);
  localparam int PRE_W = $clog2(DIV_SLOW + 1);

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] last;

  assign last = slow_mode ? PRE_W'(DIV_SLOW - 1) : PRE_W'(DIV_FAST - 1);
  assign tick = run && (pre == last);

  always_ff @(posedge clk) begin
    if (clr || restart || !run) begin
      pre <= '0;
    end else if (pre == last) begin
      pre <= '0;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (clr)
    pre <= PRE_W'(DIV_SLOW - 1)); // R4
  AST_PRESCALE_IDLE: assert property (@(posedge clk) disable iff (clr)
    !run |=> pre == '0); // R4
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
  parameter int CNT_W = 14
) (
  input  logic clk,
  input  logic clr,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic fire
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}} - 1'b1;
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  assign fire = run && tick && !restart && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (clr || restart || fire) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (clr)
    cnt != ALL1); // R5
  AST_SERVICE_ZERO: assert property (@(posedge clk) disable iff (clr)
    restart |=> cnt == '0); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (clr)
    (run && tick && !restart && cnt != LAST) |=> cnt == $past(cnt) + 1'b1); // R4
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (clr)
    (!tick && !restart) |=> $stable(cnt)); // R4
endmodule

// File: rtl/kwdt_stretch.sv
module kwdt_stretch #(
  parameter int PULSE_FAST = 98,
  parameter int PULSE_SLOW = 196
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic slow_mode,
  output logic busy
);
  localparam int PW = $clog2(PULSE_SLOW + 1);

  logic [PW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
    end else if (fire) begin
      busy <= 1'b1;
      left <= slow_mode ? PW'(PULSE_SLOW - 1) : PW'(PULSE_FAST - 1);
    end else if (busy) begin
      if (left == '0) begin
        busy <= 1'b0;
      end else begin
        left <= left - 1'b1;
      end
    end
  end

  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && left != '0) |=> busy); // R8
  AST_PULSE_END: assert property (@(posedge clk) disable iff (rst)
    (busy && left == '0 && !fire) |=> !busy); // R8
  AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
    fire |=> busy); // R5
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_A = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B = 8'hE1,
  parameter int CNT_W = 14,
  parameter int DIV_FAST = 6,
  parameter int DIV_SLOW = 12,
  parameter int PULSE_FAST = 98,
  parameter int PULSE_SLOW = 196
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_slow,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_we,
  output logic              rst_out
);
  logic core_clr;
  logic key_hit;
  logic armed;
  logic tick;
  logic fire;

  assign core_clr = rst || rst_out;

  kwdt_key_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR),
    .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_key (
    .clk(clk), .clr(core_clr), .wr_en(sfr_we), .wr_addr(sfr_addr),
    .wr_data(sfr_wdata), .key_hit(key_hit)
  );

  always_ff @(posedge clk) begin
    if (core_clr || fire) begin
      armed <= 1'b0;
    end else if (key_hit) begin
      armed <= 1'b1;
    end
  end

  kwdt_prescale #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_pre (
    .clk(clk), .clr(core_clr), .run(armed), .restart(key_hit),
    .slow_mode(mode_slow), .tick(tick)
  );

  kwdt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .clr(core_clr), .run(armed), .restart(key_hit),
    .tick(tick), .fire(fire)
  );

  kwdt_stretch #(.PULSE_FAST(PULSE_FAST), .PULSE_SLOW(PULSE_SLOW)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire), .slow_mode(mode_slow), .busy(rst_out)
  );

  AST_RST_IDLE: assert property (@(posedge clk)
    rst |=> (!armed && !rst_out)); // R1
  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (armed && !rst_out && !fire) |=> armed); // R3
  AST_DISARM_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
    rst_out |-> !armed); // R9
  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    fire |-> armed); // R9
endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CNT_W   = 6;
  localparam int MAXC       = (1 << TB_CNT_W) - 1;
  localparam int QUIET      = MAXC * 12 + 150;

  typedef struct {
    int    start;
    int    width;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_slow = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic       sfr_we = 1'b0;
  logic       rst_out;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  int   pulses = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  keyed_wdt #(.CNT_W(TB_CNT_W)) u_keyed_wdt (
    .clk(clk), .rst(rst), .mode_slow(mode_slow), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_we(sfr_we), .rst_out(rst_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor: compares every observed pulse with the queue front
  logic prev = 1'b0;
  int   rise = 0;
  always @(negedge clk) begin
    if (rst_out && !prev) rise = cyc;
    if (!rst_out && prev) begin
      pulses++;
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected pulse", rise, -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rise == e.start, e.req, rise, e.start);
        check((cyc - rise) == e.width, "R8 width", cyc - rise, e.width);
      end
    end
    prev = rst_out;
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int k);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
    k = cyc;
  endtask

  task automatic expect_pulse(input int k, input string req);
    exp_t e;
    int div;
    div = mode_slow ? 12 : 6;
    e.start = k + MAXC * div;
    e.width = mode_slow ? 196 : 98;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string req);
    int p0;
    p0 = pulses;
    repeat (n) @(negedge clk);
    check(pulses == p0 && !rst_out, req, pulses - p0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    int k;
    int f;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(rst_out == 1'b0, "R1 reset state", rst_out, 0);
    quiet(QUIET, "R1 idle without key");

    // arm in fast mode, no service
    wr(8'hA6, 8'h1E, k); wr(8'hA6, 8'hE1, k);
    expect_pulse(k, "R2/R4/R5 fast overflow start");
    drain();
    quiet(QUIET, "R9 disarmed after overflow");

    // lone second byte, interrupted key, repeated first byte
    wr(8'hA6, 8'hE1, k);
    quiet(QUIET, "R7 lone second byte");
    wr(8'hA6, 8'h1E, k); wr(8'hA6, 8'h55, k); wr(8'hA6, 8'hE1, k);
    quiet(QUIET, "R7 interrupted key");
    wr(8'hA6, 8'h1E, k); wr(8'hA6, 8'h1E, k); wr(8'hA6, 8'hE1, k);
    quiet(QUIET, "R7 repeated first byte");

    // foreign-address write between the key bytes does not disturb the detector
    wr(8'hA6, 8'h1E, k); wr(8'h80, 8'h00, k); wr(8'h81, 8'hE1, k); wr(8'hA6, 8'hE1, k);
    expect_pulse(k, "R7 foreign write ignored");
    drain();

    // service several times, with bad writes that must not disarm
    wr(8'hA6, 8'h1E, k); wr(8'hA6, 8'hE1, k);
    for (int i = 0; i < 4; i++) begin
      repeat (250) @(negedge clk);
      wr(8'hA6, 8'h00, k); wr(8'hA6, 8'h1E, k); wr(8'hA6, 8'h77, k);
      wr(8'hA6, 8'h1E, k); wr(8'hA6, 8'hE1, k);
      check(rst_out == 1'b0, "R6 no pulse while serviced", rst_out, 0);
    end
    expect_pulse(k, "R3/R6 overflow after last service");
    drain();

    // slow mode: 12-clock machine cycle and 196-clock pulse
    mode_slow = 1'b1;
    wr(8'hA6, 8'h1E, k); wr(8'hA6, 8'hE1, k);
    expect_pulse(k, "R4/R5 slow overflow start");
    drain();

    // key writes during the pulse are ignored
    wr(8'hA6, 8'h1E, k); wr(8'hA6, 8'hE1, k);
    expect_pulse(k, "R5 slow overflow before ignored key");
    while (!rst_out) @(negedge clk);
    wr(8'hA6, 8'h1E, k); wr(8'hA6, 8'hE1, k);
    drain();
    quiet(QUIET, "R9 key during pulse ignored");

    // hardware reset mid-count
    mode_slow = 1'b0;
    wr(8'hA6, 8'h1E, k); wr(8'hA6, 8'hE1, k);
    repeat (200) @(negedge clk);
    do_reset();
    quiet(QUIET, "R10 reset mid-count");

    // hardware reset mid-pulse cuts it short
    wr(8'hA6, 8'h1E, k); wr(8'hA6, 8'hE1, k);
    f = k + MAXC * 6;
    begin
      exp_t e;
      e.start = f; e.width = 11; e.req = "R10 pulse before reset";
      sb.push_back(e);
    end
    while (cyc != f + 10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(rst_out == 1'b0, "R10 reset drops pulse", rst_out, 0);
    rst = 1'b0;
    drain();
    quiet(QUIET, "R10 disarmed after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule